// File: doc/BRIEF.md
# Reusable Block Table (first level)

This block keeps a short list of memory blocks that have died, so that the memory allocator can hand them out again instead of carving new space. A block enters the list when hardware reference counting sees its count drop to zero. Each block is kept as an address and a size class. The size class is the object size in units of 8 bytes. The allocator sends a reuse request carrying a size class. One cycle later it receives either the address of a held block of exactly that class, or zero. A zero tells the allocator to take its own allocation path.

The list is the small first level of a two-level arrangement. On a miss, the block raises a refill request toward the larger second level when that level reports a block of the missed class. Blocks pushed down from the second level come in through a fill port. When a new dead block arrives and the list is full, the oldest held block is spilled to the second level. An allocate-notify port reports each newly created object by address and size. If that address is still held here, it is dropped so that it cannot be handed out again.

Top module: `fbt_l1`

## Requirements
- R1: After reset the table is empty. `rsp_valid`, `spill_valid` and `refill_req` are low, and a first reuse request of any class returns address 0.
- R2: A reuse request presented in cycle N gives `rsp_valid` high in cycle N+1 only. `rsp_addr` is the address of the oldest held block whose size class equals `req_size` exactly. If no such block is held, `rsp_addr` is 0.
- R3: A block returned by a reuse request is removed in the same cycle. A later request of the same class returns the next oldest block of that class, or 0.
- R4: A dead-block insertion (`dead_valid`) adds its address and class as the newest entry. An insertion with address 0 is ignored.
- R5: An insertion into a table that already holds `DEPTH` (8) blocks spills the oldest block. That block appears on `spill_valid`/`spill_addr`/`spill_size` one cycle later, and the new block is kept.
- R6: An allocate-notify whose address equals a held block's address removes that block. A notify that matches no held block changes nothing.
- R7: In a response cycle that returns 0, `refill_req` is high exactly when `l2_hit` is high. In that cycle `refill_size` carries the class of the missed request.
- R8: A fill block is accepted only while `fill_ready` is high, which is whenever `dead_valid` is low. It is then inserted like a dead block. A fill offered while `fill_ready` is low is not taken.
- R9: In one cycle, an allocate-notify removal is applied first, then the reuse lookup and its removal, and then the insertion. A lookup hit in a full table therefore frees a slot, so a same-cycle insertion does not spill. A block removed by a same-cycle notify is never returned.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Reuse request strobe |
| req_size | input | 12 | Requested size class (8-byte units) |
| rsp_valid | output | 1 | Response strobe, one cycle after the request |
| rsp_addr | output | 32 | Reused block address, 0 on miss |
| dead_valid | input | 1 | Dead-block insertion strobe |
| dead_addr | input | 32 | Dead block address |
| dead_size | input | 12 | Dead block size class |
| alloc_valid | input | 1 | Allocate-notify strobe |
| alloc_addr | input | 32 | New object address |
| alloc_size | input | 12 | New object size class |
| l2_hit | input | 1 | Second level holds a block of `refill_size` |
| refill_req | output | 1 | Refill request to the second level |
| refill_size | output | 12 | Class wanted by the refill |
| fill_valid | input | 1 | Fill block strobe from the second level |
| fill_addr | input | 32 | Fill block address |
| fill_size | input | 12 | Fill block size class |
| fill_ready | output | 1 | Fill port can take a block this cycle |
| spill_valid | output | 1 | Spilled block strobe to the second level |
| spill_addr | output | 32 | Spilled block address |
| spill_size | output | 12 | Spilled block size class |

## Verification
Two collisions can happen in a single cycle. In the first, a reuse hit and a dead-block insertion meet while the table is full. The bench fills all eight slots, then drives a request for a held class together with a new dead block. It expects the hit address, no spill, and the new block to be retrievable afterwards. In the second, an allocate-notify and a reuse request target the same block in one cycle. The expected response is zero.

// File: rtl/fbt_pkg.sv
package fbt_pkg;
    localparam int ADDR_W = 32;
    localparam int CLS_W  = 12;

    typedef struct packed {
        logic [ADDR_W-1:0] addr;
        logic [CLS_W-1:0]  cls;
    } blk_t;
endpackage

// File: rtl/fbt_match.sv
// Parallel equality compare of one key against every live slot.
module fbt_match #(
    parameter int N = 8,
    parameter int W = 12
) (
    input  logic [N*W-1:0] keys_flat,
    input  logic [N-1:0]   live,
    input  logic [W-1:0]   key,
    output logic [N-1:0]   hit
);
    for (genvar i = 0; i < N; i++) begin : g_cmp
        assign hit[i] = live[i] && (keys_flat[i*W +: W] == key);
    end
endmodule

// File: rtl/fbt_first.sv
// Lowest-index set bit: slot 0 is the oldest entry.
module fbt_first #(
    parameter int N  = 8,
    localparam int IW = (N > 1) ? $clog2(N) : 1
) (
    input  logic [N-1:0]  vec,
    output logic          any,
    output logic [IW-1:0] idx
);
    always_comb begin
        any = 1'b0;
        idx = '0;
        for (int i = N - 1; i >= 0; i--) begin
            if (vec[i]) begin
                any = 1'b1;
                idx = IW'(i);
            end
        end
    end
endmodule

// File: rtl/fbt_l1.sv
module fbt_l1
    import fbt_pkg::*;
#(
    parameter int DEPTH = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              req_valid,
    input  logic [CLS_W-1:0]  req_size,
    output logic              rsp_valid,
    output logic [ADDR_W-1:0] rsp_addr,
    input  logic              dead_valid,
    input  logic [ADDR_W-1:0] dead_addr,
    input  logic [CLS_W-1:0]  dead_size,
    input  logic              alloc_valid,
    input  logic [ADDR_W-1:0] alloc_addr,
    input  logic [CLS_W-1:0]  alloc_size,
    input  logic              l2_hit,
    output logic              refill_req,
    output logic [CLS_W-1:0]  refill_size,
    input  logic              fill_valid,
    input  logic [ADDR_W-1:0] fill_addr,
    input  logic [CLS_W-1:0]  fill_size,
    output logic              fill_ready,
    output logic              spill_valid,
    output logic [ADDR_W-1:0] spill_addr,
    output logic [CLS_W-1:0]  spill_size
);
    localparam int IW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
    localparam int CW = $clog2(DEPTH + 1);

    typedef blk_t [DEPTH-1:0] ent_arr_t;

    typedef struct packed {
        ent_arr_t          ent;
        logic [CW-1:0]     cnt;
        logic              rsp_v;
        logic [ADDR_W-1:0] rsp_a;
        logic [CLS_W-1:0]  rsp_c;
        logic              sp_v;
        blk_t              sp;
    } st_t;

    st_t st_q, st_d;

    function automatic ent_arr_t drop(input ent_arr_t a, input logic [IW-1:0] k);
        ent_arr_t r;
        r = a;
        for (int i = 0; i < DEPTH - 1; i++) begin
            if (i >= int'(k)) r[i] = a[i+1];
        end
        r[DEPTH-1] = '0;
        return r;
    endfunction

    // live slot mask and flattened keys
    logic [DEPTH-1:0]        live_w;
    logic [DEPTH*ADDR_W-1:0] addr_flat;
    logic [DEPTH*CLS_W-1:0]  cls_flat;
    for (genvar i = 0; i < DEPTH; i++) begin : g_flat
        assign live_w[i] = (i < int'(st_q.cnt));
        assign addr_flat[i*ADDR_W +: ADDR_W] = st_q.ent[i].addr;
        assign cls_flat[i*CLS_W +: CLS_W]    = st_q.ent[i].cls;
    end

    // allocate-notify address match (applied first)
    logic [DEPTH-1:0] a_live, a_hit;
    logic             a_any;
    logic [IW-1:0]    a_idx;
    assign a_live = alloc_valid ? live_w : '0;

    fbt_match #(.N(DEPTH), .W(ADDR_W)) u_amatch (
        .keys_flat(addr_flat), .live(a_live), .key(alloc_addr), .hit(a_hit)
    );
    fbt_first #(.N(DEPTH)) u_afirst (.vec(a_hit), .any(a_any), .idx(a_idx));

    // size-class lookup over what the notify leaves
    logic [DEPTH-1:0] a_mask, s_live, s_hit;
    logic             s_any;
    logic [IW-1:0]    s_idx;
    assign a_mask = a_any ? (DEPTH'(1) << a_idx) : '0;
    assign s_live = req_valid ? (live_w & ~a_mask) : '0;

    fbt_match #(.N(DEPTH), .W(CLS_W)) u_smatch (
        .keys_flat(cls_flat), .live(s_live), .key(req_size), .hit(s_hit)
    );
    fbt_first #(.N(DEPTH)) u_sfirst (.vec(s_hit), .any(s_any), .idx(s_idx));

    // insertion source: dead blocks take precedence over fills
    logic ins_v;
    blk_t ins_b;
    always_comb begin
        ins_v = 1'b0;
        ins_b = '0;
        if (dead_valid) begin
            ins_v = (dead_addr != '0);
            ins_b = '{addr: dead_addr, cls: dead_size};
        end else if (fill_valid) begin
            ins_v = (fill_addr != '0);
            ins_b = '{addr: fill_addr, cls: fill_size};
        end
    end

    always_comb begin
        st_d       = st_q;
        st_d.rsp_v = req_valid;
        st_d.rsp_a = '0;
        st_d.sp_v  = 1'b0;
        if (req_valid) st_d.rsp_c = req_size;
        if (s_any) st_d.rsp_a = st_q.ent[s_idx].addr;

        // removals, higher index first so the lower index stays valid
        if (a_any && s_any) begin
            if (a_idx > s_idx) begin
                st_d.ent = drop(drop(st_q.ent, a_idx), s_idx);
            end else begin
                st_d.ent = drop(drop(st_q.ent, s_idx), a_idx);
            end
            st_d.cnt = st_q.cnt - CW'(2);
        end else if (a_any) begin
            st_d.ent = drop(st_q.ent, a_idx);
            st_d.cnt = st_q.cnt - CW'(1);
        end else if (s_any) begin
            st_d.ent = drop(st_q.ent, s_idx);
            st_d.cnt = st_q.cnt - CW'(1);
        end

        // insertion at the young end, spilling the oldest when full
        if (ins_v) begin
            if (st_d.cnt == CW'(DEPTH)) begin
                st_d.sp_v           = 1'b1;
                st_d.sp             = st_d.ent[0];
                st_d.ent            = drop(st_d.ent, '0);
                st_d.ent[DEPTH-1]   = ins_b;
            end else begin
                for (int i = 0; i < DEPTH; i++) begin
                    if (i == int'(st_d.cnt)) st_d.ent[i] = ins_b;
                end
                st_d.cnt = st_d.cnt + CW'(1);
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign rsp_valid   = st_q.rsp_v;
    assign rsp_addr    = st_q.rsp_a;
    assign refill_req  = st_q.rsp_v && (st_q.rsp_a == '0) && l2_hit;
    assign refill_size = st_q.rsp_c;
    assign fill_ready  = !dead_valid;
    assign spill_valid = st_q.sp_v;
    assign spill_addr  = st_q.sp.addr;
    assign spill_size  = st_q.sp.cls;

    logic unused_ok;
    assign unused_ok = ^alloc_size;

    // ---------------- assertions ----------------
    assert_rsp_follows_req_R2: assert property (@(posedge clk) disable iff (!rst_n)
        req_valid |=> rsp_valid);
    assert_rsp_only_after_req_R2: assert property (@(posedge clk) disable iff (!rst_n)
        !req_valid |=> !rsp_valid);
    assert_spill_only_when_full_R5: assert property (@(posedge clk) disable iff (!rst_n)
        spill_valid |-> $past(st_q.cnt) == CW'(DEPTH));
    assert_zero_addr_ignored_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (dead_valid && dead_addr == '0 && !req_valid && !alloc_valid)
        |=> st_q.cnt == $past(st_q.cnt));
    assert_hit_removes_entry_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (rsp_valid && rsp_addr != '0 && !$past(ins_v) && !$past(a_any))
        |-> st_q.cnt == $past(st_q.cnt) - CW'(1));
    assert_notify_removes_entry_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (a_any && !s_any && !ins_v) |=> st_q.cnt == $past(st_q.cnt) - CW'(1));
endmodule

// File: tb/sim_fbt_l1.sv
module sim_fbt_l1;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        req_valid = 0, dead_valid = 0, alloc_valid = 0, fill_valid = 0, l2_hit = 0;
    logic [11:0] req_size = 0, dead_size = 0, alloc_size = 0, fill_size = 0;
    logic [31:0] dead_addr = 0, alloc_addr = 0, fill_addr = 0;
    logic        rsp_valid, refill_req, fill_ready, spill_valid;
    logic [31:0] rsp_addr, spill_addr;
    logic [11:0] refill_size, spill_size;

    int nchk = 0, nbad = 0;
    bit done = 0;
    logic [31:0] exp_q[$];
    string       tag_q[$];

    always #2 clk = ~clk;

    fbt_l1 u0 (
        .clk(clk), .rst_n(rst_n),
        .req_valid(req_valid), .req_size(req_size),
        .rsp_valid(rsp_valid), .rsp_addr(rsp_addr),
        .dead_valid(dead_valid), .dead_addr(dead_addr), .dead_size(dead_size),
        .alloc_valid(alloc_valid), .alloc_addr(alloc_addr), .alloc_size(alloc_size),
        .l2_hit(l2_hit), .refill_req(refill_req), .refill_size(refill_size),
        .fill_valid(fill_valid), .fill_addr(fill_addr), .fill_size(fill_size),
        .fill_ready(fill_ready),
        .spill_valid(spill_valid), .spill_addr(spill_addr), .spill_size(spill_size)
    );

    task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
        nchk++;
        if (act !== exp) begin
            nbad++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    // monitor: pop expected responses as the design produces them
    always @(negedge clk) begin
        if (rst_n && rsp_valid) begin
            if (exp_q.size() == 0) check("R2 unexpected response", 32'h1, 32'h0);
            else check(tag_q.pop_front(), rsp_addr, exp_q.pop_front());
        end
    end

    task automatic tick();
        @(negedge clk);
        req_valid = 0; dead_valid = 0; alloc_valid = 0; fill_valid = 0;
    endtask

    task automatic ask(input logic [11:0] c, input logic [31:0] e, input string tag);
        req_valid = 1; req_size = c;
        exp_q.push_back(e); tag_q.push_back(tag);
        tick();
    endtask

    task automatic put(input logic [31:0] a, input logic [11:0] c);
        dead_valid = 1; dead_addr = a; dead_size = c;
        tick();
    endtask

    initial begin
        #80000;
        if (!done) begin
            nbad++; nchk++;
            $display("FAIL watchdog actual=hung expected=finish");
            $display("test done: total=%0d bad=%0d", nchk, nbad);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1;
        check("R1 rsp_valid reset", {31'b0, rsp_valid}, 0);
        check("R1 spill_valid reset", {31'b0, spill_valid}, 0);
        check("R1 refill_req reset", {31'b0, refill_req}, 0);
        ask(12'd5, 0, "R1 empty table miss");

        put(32'h1000, 4); put(32'h2000, 4); put(32'h3000, 7);
        ask(4, 32'h1000, "R2 oldest of class");
        ask(4, 32'h2000, "R3 next after removal");
        ask(4, 0, "R3 class exhausted");
        ask(3, 0, "R2 exact class only");

        put(32'h0, 9);
        ask(9, 0, "R4 zero address ignored");

        alloc_valid = 1; alloc_addr = 32'h3000; tick();
        ask(7, 0, "R6 notify removes block");
        put(32'h4000, 2);
        alloc_valid = 1; alloc_addr = 32'h5000; tick();
        ask(2, 32'h4000, "R6 unmatched notify no effect");

        l2_hit = 1;
        ask(11, 0, "R7 miss response");
        check("R7 refill_req on miss with l2_hit", {31'b0, refill_req}, 1);
        check("R7 refill_size", {20'b0, refill_size}, 11);
        l2_hit = 0;
        ask(12, 0, "R7 miss without l2_hit");
        check("R7 no refill without l2_hit", {31'b0, refill_req}, 0);

        fill_valid = 1; fill_addr = 32'h6000; fill_size = 11; #1;
        check("R8 fill_ready idle", {31'b0, fill_ready}, 1);
        tick();
        ask(11, 32'h6000, "R8 fill block inserted");
        dead_valid = 1; dead_addr = 32'h7000; dead_size = 1;
        fill_valid = 1; fill_addr = 32'h7100; fill_size = 1; #1;
        check("R8 fill_ready low during dead insert", {31'b0, fill_ready}, 0);
        tick();
        ask(1, 32'h7000, "R8 dead block kept");
        ask(1, 0, "R8 blocked fill not taken");

        for (int i = 0; i < 8; i++) put(32'h10000 + 32'(i) * 32'h100, 12'(20 + i));
        check("R5 no spill while filling", {31'b0, spill_valid}, 0);
        put(32'h20000, 30);
        check("R5 spill strobe", {31'b0, spill_valid}, 1);
        check("R5 spill oldest addr", spill_addr, 32'h10000);
        check("R5 spill size", {20'b0, spill_size}, 20);
        ask(20, 0, "R5 spilled block gone");
        ask(30, 32'h20000, "R5 new block kept");
        put(32'h21000, 31);
        check("R5 no spill below full", {31'b0, spill_valid}, 0);

        req_valid = 1; req_size = 21;
        exp_q.push_back(32'h10100); tag_q.push_back("R9 hit in full table");
        dead_valid = 1; dead_addr = 32'h22000; dead_size = 32;
        tick();
        check("R9 hit frees slot no spill", {31'b0, spill_valid}, 0);
        ask(32, 32'h22000, "R9 same-cycle insert kept");

        req_valid = 1; req_size = 22;
        exp_q.push_back(0); tag_q.push_back("R9 notify before lookup");
        alloc_valid = 1; alloc_addr = 32'h10200;
        tick();
        ask(22, 0, "R9 notified block gone");

        repeat (2) @(negedge clk);
        check("R2 all responses seen", 32'(exp_q.size()), 0);
        done = 1;
        $display("test done: total=%0d bad=%0d", nchk, nbad);
        $finish;
    end
endmodule